// File: doc/BRIEF.md
# Serial Flash Command Frame Parser

This block is the command front end of a paged serial flash slave. It watches the chip select, serial clock and serial data lines, which are already in the system clock domain. At every chip-select falling edge it records the level of the serial clock, and so the clock mode the host is using. It shifts in an opcode byte, then three address bytes, then the number of trailing don't-care bytes that the opcode requires. When the header is complete it presents a decoded command number, a page address and a byte address, and pulses a frame-valid strobe.

A deselect before the header is complete discards the frame and raises an abort pulse. An opcode the block does not know raises a bad-command pulse and clears the command outputs. The rest of that frame is then ignored. Data transfer after the header, storage and output timing belong to neighbouring blocks.

Top module: `sflash_cmd_parser`

## Requirements
- R1: After reset `clk_idle_hi` is 1, which means the mode-3 default. `cmd`, `page_addr`, `byte_addr` and `spi_enc` are 0, and no strobe is active.
- R2: On each falling edge of `cs_n`, the level of `sck` is copied to `clk_idle_hi`. The value is held until the next falling edge of `cs_n`.
- R3: While `cs_n` is low, a bit is taken from `si` on each rising edge of `sck`, MSB first. The first 8 bits are the opcode. Next come 24 address bits: bits 23:20 are reserved and ignored, bits 19:9 are the page and bits 8:0 are the byte.
- R4: Command numbers on `cmd`:
  - 1: 68h or E8h
  - 2: 52h or D2h
  - 3: 54h or D4h
  - 4: 56h or D6h
  - 5: 57h or D7h
  - 6: 84h
  - 7: 87h
  - 8: 83h
  - 9: 86h
  - 10: 88h
  - 11: 89h
  - 12: 81h
  - 13: 50h
  - 14: 82h
  - 15: 85h
  - 16: 53h
  - 17: 55h
  - 18: 60h
  - 19: 61h
  - 20: 58h
  - 21: 59h
- R5: Field masking:
  - `page_addr` is 0 for commands 3, 4, 5, 6 and 7.
  - Command 13 forces page bits 2:0 to 0.
  - `byte_addr` is 0 for every command except 1, 2, 3, 4, 6, 7, 14 and 15.
- R6: `frame_valid` pulses once, for one cycle, after the last header bit. The header length depends on the command:
  - Commands 1 and 2: 64 bits, which includes 4 don't-care bytes.
  - Commands 3 and 4: 40 bits.
  - Command 5: 8 bits, with no address.
  - All others: 32 bits.
- R7: `cmd`, `page_addr`, `byte_addr` and `spi_enc` change only in the cycle of `frame_valid` or `cmd_bad`, and hold their values otherwise.
- R8: `spi_enc` is 1 for opcodes D2h, D4h, D6h, D7h and E8h, and 0 for every other opcode.
- R9: When `cs_n` rises after at least one bit and before `frame_valid`, `abort` pulses for one cycle, unless `cmd_bad` already fired in that frame.
- R10: An unknown opcode pulses `cmd_bad` after the 8th bit and sets `cmd`, `page_addr`, `byte_addr` and `spi_enc` to 0. The rest of that frame has no effect and gives no abort.
- R11: `sck` and `si` activity while `cs_n` is high has no effect. Bits that follow a completed header have no effect.
- R12: At most one of `frame_valid`, `cmd_bad` and `abort` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock, sampled by clk |
| si | input | 1 | Serial data in |
| clk_idle_hi | output | 1 | Level of sck seen at the last select |
| cmd | output | 5 | Decoded command number |
| spi_enc | output | 1 | Opcode used the SPI-mode encoding |
| page_addr | output | 11 | Page address |
| byte_addr | output | 9 | Byte or buffer address |
| frame_valid | output | 1 | Header complete, one-cycle strobe |
| cmd_bad | output | 1 | Unknown opcode, one-cycle strobe |
| abort | output | 1 | Early deselect, one-cycle strobe |

## Verification
Random frames draw opcodes from all 26 legal encodings, plus occasional arbitrary bytes, over random addresses and both idle clock levels. Full-length frames test the field split and masking per command. Frames cut short at random lengths separate an abort in the opcode, address or dummy phase from a clean completion, and overlong frames show that trailing data is ignored. Directed cases cover the address-less status read, block-erase page masking, an unknown opcode, a select pulse with no bits, and clock toggling while deselected. Each of these isolates one rule that random draws reach only rarely.

// File: rtl/sflash_cmd_parser.sv
`timescale 1ns/1ps
module sflash_cmd_parser #(
  parameter int RSV_W       = 4,
  parameter int PAGE_W      = 11,
  parameter int BYTE_W      = 9,
  parameter int BLK_DROP    = 3,
  parameter int LONG_DUMMY  = 4,
  parameter int SHORT_DUMMY = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              si,
  output logic              clk_idle_hi,
  output logic [4:0]        cmd,
  output logic              spi_enc,
  output logic [PAGE_W-1:0] page_addr,
  output logic [BYTE_W-1:0] byte_addr,
  output logic              frame_valid,
  output logic              cmd_bad,
  output logic              abort
);
  localparam int ADDR_W = RSV_W + PAGE_W + BYTE_W;
  localparam int FLD_W  = PAGE_W + BYTE_W;
  localparam int MAXB   = (ADDR_W > LONG_DUMMY*8) ? ADDR_W : LONG_DUMMY*8;
  localparam int CNT_W  = $clog2(MAXB);
  localparam logic [PAGE_W-1:0] BLK_MASK = ~PAGE_W'((1 << BLK_DROP) - 1);
  localparam logic [4:0] ID_STATUS = 5'd5;
  localparam logic [4:0] ID_BLOCK  = 5'd13;

  typedef enum logic [1:0] {P_IDLE, P_OPC, P_ADDR, P_DUM} phase_t;
  phase_t phase;

  logic              cs_q, sck_q;
  logic [CNT_W-1:0]  cnt;
  logic [FLD_W-2:0]  sh;
  logic [4:0]        id_q;
  logic              enc_q;
  logic [PAGE_W-1:0] pg_q;
  logic [BYTE_W-1:0] by_q;

  wire cs_fall = cs_q & ~cs_n;
  wire cs_rise = ~cs_q & cs_n;
  wire bit_in  = sck & ~sck_q & ~cs_n;
  wire [FLD_W-1:0] sh_nx = {sh, si};
  wire [7:0] op = sh_nx[7:0];

  logic [4:0] dec_id;
  logic       dec_enc;
  always_comb begin
    dec_id  = 5'd0;
    dec_enc = op[7] & op[6];
    case (op)
      8'h68, 8'hE8: dec_id = 5'd1;
      8'h52, 8'hD2: dec_id = 5'd2;
      8'h54, 8'hD4: dec_id = 5'd3;
      8'h56, 8'hD6: dec_id = 5'd4;
      8'h57, 8'hD7: dec_id = 5'd5;
      8'h84: dec_id = 5'd6;
      8'h87: dec_id = 5'd7;
      8'h83: dec_id = 5'd8;
      8'h86: dec_id = 5'd9;
      8'h88: dec_id = 5'd10;
      8'h89: dec_id = 5'd11;
      8'h81: dec_id = 5'd12;
      8'h50: dec_id = 5'd13;
      8'h82: dec_id = 5'd14;
      8'h85: dec_id = 5'd15;
      8'h53: dec_id = 5'd16;
      8'h55: dec_id = 5'd17;
      8'h60: dec_id = 5'd18;
      8'h61: dec_id = 5'd19;
      8'h58: dec_id = 5'd20;
      8'h59: dec_id = 5'd21;
      default: dec_id = 5'd0;
    endcase
  end

  wire buf_only = id_q inside {5'd3, 5'd4, 5'd6, 5'd7};
  wire has_byte = buf_only || id_q inside {5'd1, 5'd2, 5'd14, 5'd15};
  wire [CNT_W:0] ndum = (id_q inside {5'd1, 5'd2}) ? (CNT_W+1)'(LONG_DUMMY) :
                        buf_only && id_q inside {5'd3, 5'd4} ? (CNT_W+1)'(SHORT_DUMMY) :
                        '0;
  wire [CNT_W-1:0] dlast = CNT_W'(ndum * 8 - 1);

  wire [PAGE_W-1:0] pg_raw = sh_nx[BYTE_W +: PAGE_W];
  wire [PAGE_W-1:0] pg_new = buf_only ? '0 : (id_q == ID_BLOCK) ? (pg_raw & BLK_MASK) : pg_raw;
  wire [BYTE_W-1:0] by_new = has_byte ? sh_nx[BYTE_W-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= P_IDLE;
      cs_q <= 1'b1; sck_q <= 1'b1;
      cnt <= '0; sh <= '0;
      id_q <= '0; enc_q <= 1'b0; pg_q <= '0; by_q <= '0;
      clk_idle_hi <= 1'b1;
      cmd <= '0; spi_enc <= 1'b0; page_addr <= '0; byte_addr <= '0;
      frame_valid <= 1'b0; cmd_bad <= 1'b0; abort <= 1'b0;
    end else begin
      cs_q <= cs_n;
      sck_q <= sck;
      frame_valid <= 1'b0;
      cmd_bad <= 1'b0;
      abort <= 1'b0;
      if (cs_n) begin
        if (cs_rise && ((phase == P_OPC && cnt != '0) || phase == P_ADDR || phase == P_DUM))
          abort <= 1'b1;
        phase <= P_IDLE;
      end else if (cs_fall) begin
        phase <= P_OPC;
        cnt <= '0;
        clk_idle_hi <= sck;
      end else if (bit_in && phase != P_IDLE) begin
        sh <= sh_nx[FLD_W-2:0];
        cnt <= cnt + CNT_W'(1);
        case (phase)
          P_OPC: if (cnt == CNT_W'(7)) begin
            cnt <= '0;
            if (dec_id == 5'd0) begin
              cmd_bad <= 1'b1;
              cmd <= '0; spi_enc <= 1'b0; page_addr <= '0; byte_addr <= '0;
              phase <= P_IDLE;
            end else if (dec_id == ID_STATUS) begin
              frame_valid <= 1'b1;
              cmd <= dec_id; spi_enc <= dec_enc; page_addr <= '0; byte_addr <= '0;
              phase <= P_IDLE;
            end else begin
              id_q <= dec_id;
              enc_q <= dec_enc;
              phase <= P_ADDR;
            end
          end
          P_ADDR: if (cnt == CNT_W'(ADDR_W-1)) begin
            cnt <= '0;
            pg_q <= pg_new;
            by_q <= by_new;
            if (ndum == '0) begin
              frame_valid <= 1'b1;
              cmd <= id_q; spi_enc <= enc_q; page_addr <= pg_new; byte_addr <= by_new;
              phase <= P_IDLE;
            end else begin
              phase <= P_DUM;
            end
          end
          P_DUM: if (cnt == dlast) begin
            frame_valid <= 1'b1;
            cmd <= id_q; spi_enc <= enc_q; page_addr <= pg_q; byte_addr <= by_q;
            phase <= P_IDLE;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/sflash_cmd_parser_chk.sv
`timescale 1ns/1ps
module sflash_cmd_parser_chk #(
  parameter int PAGE_W   = 11,
  parameter int BYTE_W   = 9,
  parameter int BLK_DROP = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n,
  input logic              clk_idle_hi,
  input logic [4:0]        cmd,
  input logic              spi_enc,
  input logic [PAGE_W-1:0] page_addr,
  input logic [BYTE_W-1:0] byte_addr,
  input logic              frame_valid,
  input logic              cmd_bad,
  input logic              abort
);
  AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({frame_valid, cmd_bad, abort})); // R12
  AST_ABORT_AT_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    abort |-> $past(cs_n) && !$past(cs_n, 2)); // R9
  AST_VALID_WHILE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |-> !$past(cs_n)); // R11
  AST_MODE_AT_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(clk_idle_hi) |-> !$past(cs_n) && $past(cs_n, 2)); // R2
  AST_BAD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_bad |-> cmd == '0 && page_addr == '0 && byte_addr == '0 && !spi_enc); // R10
  AST_BLOCK_PAGE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid && cmd == 5'd13 |-> page_addr[BLK_DROP-1:0] == '0); // R5
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_valid && !cmd_bad |-> $stable(cmd) && $stable(page_addr) && $stable(byte_addr) && $stable(spi_enc)); // R7
  AST_VALID_KNOWN_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |-> cmd != 5'd0 && cmd <= 5'd21); // R4
endmodule

bind sflash_cmd_parser sflash_cmd_parser_chk #(.PAGE_W(PAGE_W), .BYTE_W(BYTE_W), .BLK_DROP(BLK_DROP)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .clk_idle_hi(clk_idle_hi), .cmd(cmd),
  .spi_enc(spi_enc), .page_addr(page_addr), .byte_addr(byte_addr),
  .frame_valid(frame_valid), .cmd_bad(cmd_bad), .abort(abort));

// File: tb/sim_sflash_cmd_parser.sv
`timescale 1ns/1ps
module sim_sflash_cmd_parser;
  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sck = 1'b1, si = 1'b0;
  logic clk_idle_hi, spi_enc, frame_valid, cmd_bad, abort;
  logic [4:0] cmd;
  logic [10:0] page_addr;
  logic [8:0] byte_addr;

  sflash_cmd_parser u0 (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
    .clk_idle_hi(clk_idle_hi), .cmd(cmd), .spi_enc(spi_enc), .page_addr(page_addr),
    .byte_addr(byte_addr), .frame_valid(frame_valid), .cmd_bad(cmd_bad), .abort(abort));

  always #4 clk = ~clk;

  int checks = 0, fails = 0;
  int nv = 0, nb = 0, na = 0;
  logic [4:0] e_cmd = '0;
  logic [10:0] e_pg = '0;
  logic [8:0] e_by = '0;
  logic e_enc = 1'b0;

  logic [7:0] ops [26] = '{8'h68, 8'hE8, 8'h52, 8'hD2, 8'h54, 8'hD4, 8'h56, 8'hD6, 8'h57, 8'hD7,
    8'h84, 8'h87, 8'h83, 8'h86, 8'h88, 8'h89, 8'h81, 8'h50, 8'h82, 8'h85, 8'h53, 8'h55,
    8'h60, 8'h61, 8'h58, 8'h59};

  always @(negedge clk) if (rst_n) begin
    if (frame_valid) nv++;
    if (cmd_bad) nb++;
    if (abort) na++;
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int ref_id(input logic [7:0] o);
    case (o)
      8'h68, 8'hE8: return 1;  8'h52, 8'hD2: return 2;
      8'h54, 8'hD4: return 3;  8'h56, 8'hD6: return 4;
      8'h57, 8'hD7: return 5;  8'h84: return 6;  8'h87: return 7;
      8'h83: return 8;  8'h86: return 9;  8'h88: return 10; 8'h89: return 11;
      8'h81: return 12; 8'h50: return 13; 8'h82: return 14; 8'h85: return 15;
      8'h53: return 16; 8'h55: return 17; 8'h60: return 18; 8'h61: return 19;
      8'h58: return 20; 8'h59: return 21;
      default: return 0;
    endcase
  endfunction

  function automatic int ref_len(input int id);
    if (id == 5) return 8;
    if (id == 1 || id == 2) return 64;
    if (id == 3 || id == 4) return 40;
    return 32;
  endfunction

  function automatic logic [10:0] ref_pg(input int id, input logic [23:0] a);
    if (id inside {3, 4, 5, 6, 7}) return '0;
    if (id == 13) return {a[19:12], 3'b000};
    return a[19:9];
  endfunction

  function automatic logic [8:0] ref_by(input int id, input logic [23:0] a);
    if (id inside {1, 2, 3, 4, 6, 7, 14, 15}) return a[8:0];
    return '0;
  endfunction

  function automatic bit ref_enc(input logic [7:0] o);
    return o inside {8'hD2, 8'hD4, 8'hD6, 8'hD7, 8'hE8};
  endfunction

  task automatic send(input bit idle, input logic [95:0] fr, input int nbits);
    @(negedge clk); sck = idle; cs_n = 1'b1;
    repeat (3) @(negedge clk);
    cs_n = 1'b0;
    repeat (2) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      sck = 1'b0; si = fr[95-i];
      repeat (2) @(negedge clk);
      sck = 1'b1;
      repeat (2) @(negedge clk);
    end
    sck = idle;
    repeat (2) @(negedge clk);
    cs_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic frame(input bit idle, input logic [7:0] o, input logic [23:0] a, input int nbits);
    int id, hdr, xv, xb, xa;
    logic [95:0] fr;
    fr = {o, a, $urandom(), $urandom()};
    id = ref_id(o);
    hdr = ref_len(id);
    xv = 0; xb = 0; xa = 0;
    nv = 0; nb = 0; na = 0;
    send(idle, fr, nbits);
    if (nbits == 0) ;
    else if (nbits < 8) xa = 1;
    else if (id == 0) begin
      xb = 1; e_cmd = '0; e_pg = '0; e_by = '0; e_enc = 1'b0;
    end else if (nbits < hdr) xa = 1;
    else begin
      xv = 1; e_cmd = 5'(id); e_pg = ref_pg(id, a); e_by = ref_by(id, a); e_enc = ref_enc(o);
    end
    chk(nv == xv, "R6 frame_valid count", nv, xv);
    chk(nb == xb, "R10 cmd_bad count", nb, xb);
    chk(na == xa, "R9 abort count", na, xa);
    chk(nv + nb + na <= 1, "R12 single strobe", nv + nb + na, 1);
    chk(cmd == e_cmd, xa ? "R7 cmd held" : "R4 cmd", cmd, e_cmd);
    chk(page_addr == e_pg, xa ? "R7 page held" : "R5 page", page_addr, e_pg);
    chk(byte_addr == e_by, xa ? "R7 byte held" : "R3 byte", byte_addr, e_by);
    chk(spi_enc == e_enc, "R8 spi_enc", spi_enc, e_enc);
    chk(clk_idle_hi == idle, "R2 idle level", clk_idle_hi, idle);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd7331));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(clk_idle_hi == 1'b1, "R1 mode 3 default", clk_idle_hi, 1);
    chk(cmd == 0 && page_addr == 0 && byte_addr == 0 && !spi_enc, "R1 outputs zero", cmd, 0);
    chk(!frame_valid && !cmd_bad && !abort, "R1 no strobe", {frame_valid, cmd_bad, abort}, 0);

    frame(1'b1, 8'hD7, 24'h0, 8);
    frame(1'b0, 8'h57, 24'h0, 8);
    frame(1'b1, 8'h50, 24'hF_FFFF, 32);
    frame(1'b0, 8'h84, 24'h0F_FE5A, 32);
    frame(1'b1, 8'hD2, 24'h3A_5C3, 64);
    frame(1'b0, 8'hE8, 24'h1_2345, 50);
    frame(1'b1, 8'hD4, 24'h0_81FF, 40);
    frame(1'b0, 8'h83, 24'hA_BCDE, 20);
    frame(1'b1, 8'hFF, 24'h1_2345, 40);
    frame(1'b0, 8'h3C, 24'h0, 5);
    frame(1'b1, 8'h82, 24'h5_5555, 0);
    frame(1'b1, 8'h88, 24'hF_0F0F, 80);

    nv = 0; nb = 0; na = 0;
    @(negedge clk); cs_n = 1'b1;
    for (int i = 0; i < 16; i++) begin
      sck = ~sck; si = 1'($urandom());
      repeat (2) @(negedge clk);
    end
    repeat (3) @(negedge clk);
    chk(nv + nb + na == 0, "R11 deselected no strobe", nv + nb + na, 0);
    chk(cmd == e_cmd && page_addr == e_pg && byte_addr == e_by, "R11 outputs unchanged", cmd, e_cmd);

    for (int k = 0; k < 70; k++) begin
      logic [7:0] o;
      int n;
      o = ($urandom() % 8 == 0) ? 8'($urandom()) : ops[$urandom() % 26];
      n = ref_len(ref_id(o));
      n = ($urandom() % 4 == 0) ? int'($urandom() % n) : n + int'($urandom() % 17);
      frame(1'($urandom()), o, 24'($urandom()), n);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule